// File: doc/BRIEF.md
# Transaction Commit Token Arbiter

This block hands out a single commit token to one of several processor cores, eight by default. A core that finishes a transaction raises its request line and must hold the token before it broadcasts its write set. The token stays with the holder until that core raises its commit-done line. After that, the block is idle for one cycle before the next grant.

The block works in one of two modes. In record mode it chooses freely among the waiting cores with a round-robin pointer. For every grant it emits one byte that carries the ID of the winning core, so the full commit order can be stored elsewhere. In replay mode it ignores fairness and follows a stream of previously logged bytes. It grants the token only to the core named by the entry at the head of the stream, and it consumes that entry when the holder's commit finishes.

A halt input blocks every new grant, so no further commit can start and the whole system freezes at a global breakpoint.

Top module: `commit_token_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `token_grant`, `log_out_valid` and `log_in_ready` are all zero.
- R2: `token_grant` has at most one bit set in any cycle.
- R3: Once granted, the token stays with its holder until the holder's own `commit_done` bit is high at a clock edge. It is then dropped, and `token_grant` is zero in the following cycle. `commit_done` bits of cores that do not hold the token have no effect.
- R4: In record mode, an idle and unhalted block grants, one cycle later, the first requesting core found by searching upward (with wrap-around) from a pointer. The pointer resets to core 0 and moves to the core just after each granted one.
- R5: In record mode, `log_out_valid` is high for exactly one cycle with each new grant, and in that same cycle `log_out_data[2:0]` holds the granted core's ID with bits [7:3] zero. In replay mode, `log_out_valid` stays low.
- R6: In replay mode, a grant is issued only when `log_in_valid` is high and the core whose ID is in `log_in_data[2:0]` is requesting. That core is the one granted. When the named core is not requesting, no core is granted, whatever other requests are present.
- R7: In replay mode, `log_in_ready` is high exactly in the cycles where the token is held and the holder's `commit_done` is high. `log_in_ready` is never high in record mode.
- R8: While `halt` is high, no new grant is issued. A token already held may still be released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| replay_mode | input | 1 | 0 selects record mode, 1 selects replay mode |
| halt | input | 1 | Blocks all new grants while high |
| commit_req | input | 8 | Per-core commit request |
| commit_done | input | 8 | Per-core end of commit; only the holder's bit is used |
| token_grant | output | 8 | One-hot token owner, zero when the token is free |
| log_out_valid | output | 1 | One-cycle pulse for each grant made in record mode |
| log_out_data | output | 8 | Granted core ID in bits [2:0], upper bits zero |
| log_in_valid | input | 1 | Replay log entry available |
| log_in_data | input | 8 | Replay log entry; core ID in bits [2:0] |
| log_in_ready | output | 1 | Replay log entry consumed this cycle |

## Verification
Record mode is tried three ways. With all eight cores requesting, the log must show the plain rotation 0 to 7, which confirms that the pointer starts at core 0 and moves past each winner. With a sparse request mask, the search has to skip idle cores and wrap around. A third run asserts commit-done on every core except the holder, to show that only the holder can release the token.

A halt window with all cores requesting must produce no new grant. Replay mode is driven with a log that repeats one core and jumps around the core IDs. A second replay log names a core that is not yet requesting while another core is. This separates a design that follows the log from one that falls back to any waiting core, and shows that the log entry is consumed only when the holder finishes its commit.

// File: rtl/commit_token_arbiter.sv
module commit_token_arbiter #(
  parameter int N_CORES = 8,
  parameter int LOG_W   = 8,
  localparam int ID_W   = $clog2(N_CORES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               replay_mode,
  input  logic               halt,
  input  logic [N_CORES-1:0] commit_req,
  input  logic [N_CORES-1:0] commit_done,
  output logic [N_CORES-1:0] token_grant,
  output logic               log_out_valid,
  output logic [LOG_W-1:0]   log_out_data,
  input  logic               log_in_valid,
  input  logic [LOG_W-1:0]   log_in_data,
  output logic               log_in_ready
);

  logic            held;
  logic [ID_W-1:0] owner;
  logic [ID_W-1:0] rr_ptr;
  logic [ID_W-1:0] rr_pick;
  logic            rr_found;
  logic            log_v_q;

  always_comb begin
    rr_found = 1'b0;
    rr_pick  = rr_ptr;
    for (int k = 0; k < N_CORES; k++) begin
      int c;
      c = int'(rr_ptr) + k;
      if (c >= N_CORES) c = c - N_CORES;
      if (!rr_found && commit_req[c]) begin
        rr_found = 1'b1;
        rr_pick  = ID_W'(c);
      end
    end
  end

  wire [ID_W-1:0] log_id  = log_in_data[ID_W-1:0];
  wire            rp_ok   = log_in_valid && (int'(log_id) < N_CORES) && commit_req[log_id];
  wire            release_tok = held && commit_done[owner];
  wire            win     = !held && !halt && (replay_mode ? rp_ok : rr_found);
  wire [ID_W-1:0] win_id  = replay_mode ? log_id : rr_pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held    <= 1'b0;
      owner   <= '0;
      rr_ptr  <= '0;
      log_v_q <= 1'b0;
    end else begin
      log_v_q <= win && !replay_mode;
      if (held) begin
        if (release_tok) held <= 1'b0;
      end else if (win) begin
        held  <= 1'b1;
        owner <= win_id;
        if (!replay_mode)
          rr_ptr <= (int'(rr_pick) == N_CORES - 1) ? '0 : rr_pick + 1'b1;
      end
    end
  end

  assign token_grant   = {{(N_CORES-1){1'b0}}, held} << owner;
  assign log_out_valid = log_v_q;
  assign log_out_data  = LOG_W'(owner);
  assign log_in_ready  = replay_mode && release_tok;

endmodule

module commit_token_arbiter_chk #(
  parameter int N_CORES = 8,
  parameter int LOG_W   = 8,
  localparam int ID_W   = $clog2(N_CORES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               replay_mode,
  input logic               halt,
  input logic [N_CORES-1:0] commit_req,
  input logic [N_CORES-1:0] commit_done,
  input logic [N_CORES-1:0] token_grant,
  input logic               log_out_valid,
  input logic [LOG_W-1:0]   log_out_data,
  input logic               log_in_valid,
  input logic [LOG_W-1:0]   log_in_data,
  input logic               log_in_ready
);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(token_grant)); // R2

  AST_TOKEN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (token_grant != '0) && ((token_grant & commit_done) == '0) |=> $stable(token_grant)); // R3

  AST_TOKEN_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    ((token_grant & commit_done) != '0) |=> (token_grant == '0)); // R3

  AST_HALT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    halt && (token_grant == '0) |=> (token_grant == '0)); // R8

  AST_LOG_MATCHES_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    log_out_valid |-> token_grant[log_out_data[ID_W-1:0]] && (log_out_data[LOG_W-1:ID_W] == '0)); // R5

  AST_READY_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    log_in_ready |-> replay_mode && ((token_grant & commit_done) != '0)); // R7

  AST_REPLAY_FOLLOWS_LOG: assert property (@(posedge clk) disable iff (!rst_n)
    replay_mode && !halt && (token_grant == '0) && !log_in_valid |=> (token_grant == '0)); // R6

endmodule

bind commit_token_arbiter commit_token_arbiter_chk #(.N_CORES(N_CORES), .LOG_W(LOG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .replay_mode(replay_mode), .halt(halt),
  .commit_req(commit_req), .commit_done(commit_done), .token_grant(token_grant),
  .log_out_valid(log_out_valid), .log_out_data(log_out_data),
  .log_in_valid(log_in_valid), .log_in_data(log_in_data), .log_in_ready(log_in_ready)
);

// File: tb/tb_commit_token_arbiter.sv
`timescale 1ns/1ps
module tb_commit_token_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       replay_mode = 1'b0;
  logic       halt = 1'b0;
  logic [7:0] commit_req = '0;
  logic [7:0] commit_done = '0;
  logic [7:0] token_grant;
  logic       log_out_valid;
  logic [7:0] log_out_data;
  logic       log_in_valid = 1'b0;
  logic [7:0] log_in_data = '0;
  logic       log_in_ready;

  commit_token_arbiter dut (
    .clk(clk), .rst_n(rst_n), .replay_mode(replay_mode), .halt(halt),
    .commit_req(commit_req), .commit_done(commit_done), .token_grant(token_grant),
    .log_out_valid(log_out_valid), .log_out_data(log_out_data),
    .log_in_valid(log_in_valid), .log_in_data(log_in_data), .log_in_ready(log_in_ready)
  );

  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;
  string tag = "R1";

  logic [7:0] req_mask = '0;
  logic [7:0] noise = '0;
  bit         auto_done = 1'b0;
  int         hold_cyc = 2;
  int         held_cnt = 0;
  logic [7:0] log_q[$];
  logic [7:0] rec_log[$];

  bit m_busy;
  int m_own;
  int m_ptr;
  bit m_logv;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_own = 0; m_ptr = 0; m_logv = 0;
    end else begin
      m_logv = 0;
      if (m_busy) begin
        if (commit_done[m_own]) m_busy = 0;
      end else if (!halt) begin
        if (!replay_mode) begin
          bit found;
          found = 0;
          for (int k = 0; k < 8; k++) begin
            int c;
            c = (m_ptr + k) % 8;
            if (!found && commit_req[c]) begin
              found = 1; m_busy = 1; m_own = c; m_ptr = (c + 1) % 8; m_logv = 1;
            end
          end
        end else if (log_in_valid && commit_req[log_in_data[2:0]]) begin
          m_busy = 1; m_own = int'(log_in_data[2:0]);
        end
      end
    end
  end

  always @(posedge clk)
    if (rst_n && log_in_valid && log_in_ready && log_q.size() > 0) void'(log_q.pop_front());

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [7:0] eg;
    logic       er;
    eg = m_busy ? (8'h1 << m_own) : 8'h0;
    er = replay_mode && m_busy && commit_done[m_own];
    check("token_grant", 32'(token_grant), 32'(eg));
    check("log_out_valid", 32'(log_out_valid), 32'(m_logv));
    if (m_logv) check("log_out_data", 32'(log_out_data), 32'(m_own));
    check("log_in_ready", 32'(log_in_ready), 32'(er));
    if (log_out_valid) rec_log.push_back(log_out_data);
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(negedge clk);
      commit_req = req_mask;
      commit_done = noise & ~token_grant;
      if (auto_done && token_grant != '0) begin
        held_cnt++;
        if (held_cnt >= hold_cyc) commit_done = commit_done | token_grant;
      end else held_cnt = 0;
      log_in_valid = log_q.size() > 0;
      log_in_data = (log_q.size() > 0) ? log_q[0] : 8'h00;
      #1 compare();
    end
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) begin
      @(negedge clk);
      check("grant in reset", 32'(token_grant), 0);
      check("log_out_valid in reset", 32'(log_out_valid), 0);
      check("log_in_ready in reset", 32'(log_in_ready), 0);
    end
    @(negedge clk); rst_n = 1'b1;
    #1 compare();

    tag = "R4"; req_mask = 8'hFF; auto_done = 1; hold_cyc = 2;
    run(40);
    tag = "R5";
    for (int i = 0; i < 8; i++)
      check("record log order", (rec_log.size() > i) ? 32'(rec_log[i]) : 32'hFFFF, 32'(i));

    tag = "R4"; req_mask = 8'b1010_0100; hold_cyc = 1;
    run(30);

    tag = "R3"; req_mask = 8'b0101_1011; hold_cyc = 5; noise = 8'hFF;
    run(40);
    noise = '0;

    tag = "R8"; halt = 1; req_mask = 8'hFF; hold_cyc = 1;
    run(20);
    check("no grant while halted", 32'(token_grant), 0);
    halt = 0;
    run(10);

    auto_done = 0; req_mask = '0;
    run(4);
    tag = "R6"; replay_mode = 1; auto_done = 1; hold_cyc = 2; req_mask = 8'hFF;
    log_q = '{8'd3, 8'd5, 8'd1, 8'd1, 8'd6, 8'd0};
    run(40);
    check("replay log drained", 32'(log_q.size()), 0);

    tag = "R7"; req_mask = 8'b0000_0010;
    log_q = '{8'd4, 8'd1};
    run(15);
    check("named core absent, no grant", 32'(token_grant), 0);
    check("entry not consumed", 32'(log_q.size()), 2);
    req_mask = 8'b0001_0010;
    run(20);
    check("replay log drained", 32'(log_q.size()), 0);

    tag = "R5"; rec_log.delete();
    req_mask = 8'hFF; log_q = '{8'd2, 8'd7};
    run(20);
    check("no record log in replay", 32'(rec_log.size()), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule